// File: doc/BRIEF.md
# Word-Serial Modular Adder for 256-bit Field Elements

This block adds two 256-bit field elements and reduces the sum once against a modulus. Each operand is stored in an external memory of eight 32-bit words. The block walks the operands from the least significant word upward and presents one read index, which both operand memories and the modulus memory share. All three memories answer one clock after the index is driven.

For every word the block extends two chains. One is the carry of A+B. The other is the borrow of (A+B)-N. Both the plain sum word and the reduced word are kept in internal buffers. Once the top word has been processed, one decision picks the reduced value or the plain sum. The chosen words are then written to a result memory in ascending order, one per clock.

The modulus can be the prime 2^255-19 or twice that value, which supports lazy reduction. The block never sees the whole modulus at once, and it does not know which of the two it was given. A one-cycle start pulse begins an operation. A ready flag is low for the whole operation and goes high again after the last write.

Top module: `wsum_modadd`

## Requirements
- R1: While the asynchronous active-low reset is held, and right after it is released, ready is high and the write strobe is low.
- R2: A start pulse that is sampled while ready is high is accepted. Ready is low from the next clock, and it rises exactly 17 clocks after the accepting edge, which is one clock after the last write.
- R3: After the accepting edge, the shared operand index and the modulus index take the values 0 to 7, one per clock, starting with the first clock. Data for an index is taken one clock after that index is presented.
- R4: The result equals A+B when A+B < N. Otherwise it equals A+B-N. The modulus N is read word by word. For the regular prime the words are: word 0 = 0xFFFFFFED, words 1 to 6 = 0xFFFFFFFF, word 7 = 0x7FFFFFFF. For the doubled value, word 0 = 0xFFFFFFDA and words 1 to 7 = 0xFFFFFFFF. The operands are assumed to be below N.
- R5: A sum that carries out of bit 255 always takes the reduced value.
- R6: The result goes out on 8 consecutive clocks with write addresses 0, 1, …, 7 and the strobe high. The first write appears after the 9th rising edge following the accepting edge.
- R7: A carry out of any word propagates into the word above it, and a borrow does the same.
- R8: A start pulse sampled while ready is low is ignored. It causes no extra writes and does not change the timing.
- R9: A reset asserted during an operation abandons it. Ready goes high immediately and no further writes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle start pulse |
| ready_o | output | 1 | High when idle; low while an operation runs |
| opnd_addr_o | output | 3 | Word index shared by both operand memories |
| opnd_a_i | input | 32 | Word of A, valid one clock after the index |
| opnd_b_i | input | 32 | Word of B, valid one clock after the index |
| mod_addr_o | output | 3 | Word index into the modulus memory |
| mod_word_i | input | 32 | Word of N, valid one clock after the index |
| res_addr_o | output | 3 | Result word address |
| res_data_o | output | 32 | Result word |
| res_wr_o | output | 1 | Result write strobe |

## Verification
Two events can fall on the same clock. The first is the processing of the top word, where the final carry and borrow settle the choice between the plain and the reduced sum. The second is a start pulse that arrives while the block is busy. The bench raises start during the read phase and again exactly on the top-word cycle. It then checks that all eight written words still match the expected value, which the bench computes at full 256-bit width, that no extra write appears, and that ready rises on the 17th clock.

// File: rtl/wsum_pkg.sv
package wsum_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_WRITE = 2'd3
  } wsum_state_e;

  // Sum word with carry out on the top bit.
  function automatic logic [WORD_W:0] word_add(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b,
                                               input logic             ci);
    return {1'b0, a} + {1'b0, b} + {{WORD_W{1'b0}}, ci};
  endfunction

  // Difference word with borrow out on the top bit.
  function automatic logic [WORD_W:0] word_sub(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] n,
                                               input logic             bi);
    return {1'b0, a} - {1'b0, n} - {{WORD_W{1'b0}}, bi};
  endfunction

  // Reduced value wins on carry out of the top or no final borrow.
  function automatic logic choose_reduced(input logic carry_top,
                                          input logic borrow_top);
    return carry_top | ~borrow_top;
  endfunction

endpackage

// File: rtl/wsum_seq.sv
module wsum_seq
  import wsum_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             ready_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             dat_vld_o,
  output logic [IDX_W-1:0] dat_idx_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

  wsum_state_e      st_q;
  logic [IDX_W-1:0] idx_q;
  logic             ev_accept;
  logic             ev_idx_last;

  assign ev_accept   = (st_q == ST_IDLE) && start_i;
  assign ev_idx_last = (idx_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      dat_vld_o <= 1'b0;
      dat_idx_o <= '0;
    end else begin
      dat_vld_o <= (st_q == ST_READ);
      dat_idx_o <= idx_q;
      unique case (st_q)
        ST_IDLE: begin
          if (ev_accept) begin
            st_q  <= ST_READ;
            idx_q <= '0;
          end
        end
        ST_READ: begin
          idx_q <= idx_q + 1'b1;
          if (ev_idx_last) st_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          st_q  <= ST_WRITE;
          idx_q <= '0;
        end
        ST_WRITE: begin
          idx_q <= idx_q + 1'b1;
          if (ev_idx_last) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o  = (st_q == ST_IDLE);
  assign rd_idx_o = idx_q;
  assign wr_en_o  = (st_q == ST_WRITE);
  assign wr_idx_o = idx_q;

  // R3: data words arrive in ascending order, one per clock
  a_r3_data_order: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_vld_o && $past(dat_vld_o)) |-> dat_idx_o == $past(dat_idx_o) + 1'b1);

  // R8: a start while busy never changes the state directly
  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && start_i && st_q == ST_READ && !ev_idx_last) |=> st_q == ST_READ);

endmodule

// File: rtl/wsum_chain.sv
module wsum_chain
  import wsum_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat_vld_i,
  input  logic [IDX_W-1:0]  dat_idx_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [WORD_W-1:0] n_i,
  output logic [WORD_W-1:0] raw_o,
  output logic [WORD_W-1:0] red_o,
  output logic              pick_red_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

  logic              carry_q, borrow_q;
  logic              cin, bin;
  logic [WORD_W:0]   s_ext, d_ext;
  logic              ev_first, ev_top;

  assign ev_first = (dat_idx_i == '0);
  assign ev_top   = dat_vld_i && (dat_idx_i == LAST);

  // word 0 starts both chains clean, so no clearing cycle is needed
  assign cin   = ev_first ? 1'b0 : carry_q;
  assign bin   = ev_first ? 1'b0 : borrow_q;
  assign s_ext = word_add(a_i, b_i, cin);
  assign d_ext = word_sub(s_ext[WORD_W-1:0], n_i, bin);
  assign raw_o = s_ext[WORD_W-1:0];
  assign red_o = d_ext[WORD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q    <= 1'b0;
      borrow_q   <= 1'b0;
      pick_red_o <= 1'b0;
    end else if (dat_vld_i) begin
      carry_q  <= s_ext[WORD_W];
      borrow_q <= d_ext[WORD_W];
      if (ev_top) pick_red_o <= choose_reduced(s_ext[WORD_W], d_ext[WORD_W]);
    end
  end

  // R4: the decision only moves on the top-word cycle
  a_r4_pick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_top |=> $stable(pick_red_o));

  // R7: chains only advance on valid data
  a_r7_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_vld_i |=> ($stable(carry_q) && $stable(borrow_q)));

endmodule

// File: rtl/wsum_buf.sv
module wsum_buf
  import wsum_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] raw_i,
  input  logic [WORD_W-1:0] red_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              pick_red_i,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-1:0] raw_q [NUM_WORDS];
  logic [WORD_W-1:0] red_q [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        raw_q[g] <= raw_i;
        red_q[g] <= red_i;
      end
    end
  end

  assign word_o = pick_red_i ? red_q[rd_idx_i] : raw_q[rd_idx_i];

endmodule

// File: rtl/wsum_modadd.sv
module wsum_modadd
  import wsum_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              ready_o,
  output logic [IDX_W-1:0]  opnd_addr_o,
  input  logic [WORD_W-1:0] opnd_a_i,
  input  logic [WORD_W-1:0] opnd_b_i,
  output logic [IDX_W-1:0]  mod_addr_o,
  input  logic [WORD_W-1:0] mod_word_i,
  output logic [IDX_W-1:0]  res_addr_o,
  output logic [WORD_W-1:0] res_data_o,
  output logic              res_wr_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

  logic              dat_vld;
  logic [IDX_W-1:0]  dat_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] raw_word, red_word;
  logic              pick_red;

  wsum_seq #(.NUM_WORDS(NUM_WORDS)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ready_o   (ready_o),
    .rd_idx_o  (rd_idx),
    .dat_vld_o (dat_vld),
    .dat_idx_o (dat_idx),
    .wr_en_o   (res_wr_o),
    .wr_idx_o  (res_addr_o)
  );

  assign opnd_addr_o = rd_idx;
  assign mod_addr_o  = rd_idx;

  wsum_chain #(.NUM_WORDS(NUM_WORDS)) chain_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dat_vld_i  (dat_vld),
    .dat_idx_i  (dat_idx),
    .a_i        (opnd_a_i),
    .b_i        (opnd_b_i),
    .n_i        (mod_word_i),
    .raw_o      (raw_word),
    .red_o      (red_word),
    .pick_red_o (pick_red)
  );

  wsum_buf #(.NUM_WORDS(NUM_WORDS)) buf_i (
    .clk        (clk),
    .wr_en_i    (dat_vld),
    .wr_idx_i   (dat_idx),
    .raw_i      (raw_word),
    .red_i      (red_word),
    .rd_idx_i   (res_addr_o),
    .pick_red_i (pick_red),
    .word_o     (res_data_o)
  );

  // R2: accepting a start drops ready on the next clock
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && start_i) |=> !ready_o);

  // R2: ready returns right after the top result word
  a_r2_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    (res_wr_o && res_addr_o == LAST) |=> ready_o);

  // R6: writes only while busy, starting at word 0 and stepping by one
  a_r6_wr_busy: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr_o |-> !ready_o);
  a_r6_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_wr_o) |-> res_addr_o == '0);
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (res_wr_o && $past(res_wr_o)) |-> res_addr_o == $past(res_addr_o) + 1'b1);

  // R4: the choice stays fixed across the whole write burst
  a_r4_pick_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (res_wr_o && $past(res_wr_o)) |-> $stable(pick_red));

endmodule

// File: tb/wsum_modadd_tb_top.sv
module wsum_modadd_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        ready_o, res_wr_o;
  logic [2:0]  opnd_addr_o, mod_addr_o, res_addr_o;
  logic [31:0] opnd_a_i, opnd_b_i, mod_word_i, res_data_o;

  logic [31:0] a_mem [8];
  logic [31:0] b_mem [8];
  logic [31:0] n_mem [8];

  int checks = 0;
  int fails  = 0;
  logic [34:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  wsum_modadd dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_o(ready_o),
    .opnd_addr_o(opnd_addr_o), .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i),
    .mod_addr_o(mod_addr_o), .mod_word_i(mod_word_i),
    .res_addr_o(res_addr_o), .res_data_o(res_data_o), .res_wr_o(res_wr_o)
  );

  // memories answer one clock after the index
  always @(posedge clk) begin
    opnd_a_i   <= a_mem[opnd_addr_o];
    opnd_b_i   <= b_mem[opnd_addr_o];
    mod_word_i <= n_mem[mod_addr_o];
  end

  localparam logic [255:0] PRIME = (256'd1 << 255) - 256'd19;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_wr_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8/R9 unexpected write", {29'd0, res_addr_o, res_data_o}, 64'd0);
      end else begin
        logic [34:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({res_addr_o, res_data_o} == e, t, {29'd0, res_addr_o, res_data_o}, {29'd0, e});
      end
    end
  end

  task automatic load(input logic [255:0] a, input logic [255:0] b, input logic [255:0] n);
    for (int i = 0; i < 8; i++) begin
      a_mem[i] = a[i*32 +: 32];
      b_mem[i] = b[i*32 +: 32];
      n_mem[i] = n[i*32 +: 32];
    end
  endtask

  task automatic run_op(input logic [255:0] a, input logic [255:0] b, input bit dbl,
                        input string tag, input int poke_at);
    logic [255:0] n;
    logic [256:0] s;
    int cyc;
    int first_wr;
    n = dbl ? {PRIME[254:0], 1'b0} : PRIME;
    load(a, b, n);
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back({i[2:0], s[i*32 +: 32]});
      tag_q.push_back(tag);
    end
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    first_wr = -1;
    while (!ready_o && cyc < 100) begin
      if (cyc <= 7)
        check(opnd_addr_o == cyc[2:0] && mod_addr_o == cyc[2:0], "R3 index",
              {58'd0, opnd_addr_o, mod_addr_o}, {58'd0, cyc[2:0], cyc[2:0]});
      start_i = (poke_at > 0) && (cyc == poke_at);
      @(negedge clk);
      cyc++;
      if (res_wr_o && first_wr < 0) first_wr = cyc;
    end
    start_i = 1'b0;
    check(cyc == 17, "R2 ready latency", cyc, 17);
    check(first_wr == 9, "R6 first write", first_wr, 9);
    check(exp_q.size() == 0, "R6 write count", exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [255:0] p2;
    p2 = {PRIME[254:0], 1'b0};
    for (int i = 0; i < 8; i++) begin
      a_mem[i] = '0; b_mem[i] = '0; n_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: state under reset
    check(ready_o == 1'b1, "R1 ready in reset", ready_o, 1);
    check(res_wr_o == 1'b0, "R1 strobe in reset", res_wr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready_o == 1'b1 && res_wr_o == 1'b0, "R1 after release", {ready_o, res_wr_o}, 2'b10);

    run_op(256'd1, 256'd2, 1'b0, "R4 small sum", 0);
    run_op(PRIME - 1, 256'd1, 1'b0, "R4 sum equals N", 0);
    run_op(PRIME - 1, PRIME - 1, 1'b0, "R4 reduce prime", 0);
    run_op(256'd5, PRIME - 6, 1'b0, "R4 just below N", 0);
    run_op(p2 - 1, p2 - 1, 1'b1, "R5 carry out top", 0);
    run_op(p2 - 1, 256'd0, 1'b1, "R4 doubled below", 0);
    run_op(256'hFFFF_FFFF, 256'd1, 1'b0, "R7 carry across word", 0);
    run_op({224'd0, 32'hFFFF_FFFF} << 96 | 256'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 256'd1, 1'b0,
           "R7 long carry ripple", 0);
    run_op(PRIME - 20, 256'd40, 1'b0, "R7 borrow chain", 0);
    run_op(256'd7, 256'd9, 1'b1, "R8 start in read phase", 3);
    run_op(PRIME - 3, 256'd10, 1'b0, "R8 start at top word", 8);
    run_op(256'd100, 256'd200, 1'b0, "R8 start in write phase", 12);

    // R9: reset in the middle of an operation
    load(256'd3, 256'd4, PRIME);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(ready_o == 1'b1, "R9 ready on reset", ready_o, 1);
    check(res_wr_o == 1'b0, "R9 strobe on reset", res_wr_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(ready_o == 1'b1, "R9 stays idle", ready_o, 1);
    run_op(PRIME - 2, 256'd2, 1'b0, "R9 op after abort", 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule